// File: doc/BRIEF.md
# Event Input Routing Cell

This cell takes a bus of asynchronous event lines and delivers one of them to a single event-driven consumer, such as a timer capture input or a converter start trigger. A select field picks the source line, and an invert bit can flip its polarity. The conditioned line then crosses into the consumer's clock domain through a flip-flop synchroniser.

Two optional stages can be switched on independently. The capture stage holds a pulse that is too narrow for the consumer clock to sample. It uses a flip-flop that the conditioned line itself sets asynchronously, and the consumer domain clears that flip-flop once the synchronised copy has been seen. The pulse stage turns each rising edge of the synchronised signal into a single-cycle strobe. Changing the source or the polarity can create a false edge, so after any such change the strobe output is held quiet for as many cycles as the synchroniser has stages.

The cell is used one per consumer. Software-visible configuration arrives as plain level inputs.

Top module: `evr_route_cell`

## Requirements
- R1: The routed line is `src_i[sel_i]`. The other bits of `src_i` have no effect on `event_o` or `sync_lvl_o`.
- R2: When `inv_i` is 1, the selected line is inverted before capture, synchronisation and shaping.
- R3: With `cap_en_i`=0 and `pulse_en_i`=0, suppose the conditioned line changes between two clock edges. `sync_lvl_o` then takes the new value after the second rising edge, and `event_o` takes it after the third.
- R4: With `pulse_en_i`=1, each rising edge of the synchronised line produces exactly one cycle of `event_o`=1, three edges after the input change. A line held high produces no further pulse.
- R5: With `cap_en_i`=1, a high pulse on the conditioned line that starts and ends between two clock edges still reaches the output. In level mode `event_o` is high after edges 3 to 5, counted from the first edge after the pulse, and low after edge 6. In pulse mode it is high for one cycle only.
- R6: With `cap_en_i`=0, a high pulse that starts and ends between two clock edges is not seen at `event_o` or `sync_lvl_o`.
- R7: In pulse mode, any change of `{sel_i, inv_i}` blocks `event_o` for 2 cycles after the change. A level difference that arises from the change therefore never produces a pulse.
- R8: While `rst_ni` is 0, `event_o` and `sync_lvl_o` are 0 and the capture flag is cleared. A pulse captured just before reset is not delivered after reset is released.
- R9: In level mode, `event_o` follows the synchronised line one cycle later, with no blanking after configuration changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Consumer (target) clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Asynchronous event source lines |
| sel_i | input | SEL_W | Index of the routed source line |
| inv_i | input | 1 | Invert the selected line |
| cap_en_i | input | 1 | Enable narrow-pulse capture |
| pulse_en_i | input | 1 | 1: single-cycle strobe output, 0: level output |
| event_o | output | 1 | Conditioned event to the consumer |
| sync_lvl_o | output | 1 | Synchronised conditioned line (status) |

## Verification
Take an input change that lands between two clock edges. `sync_lvl_o` is due after the second rising edge that follows it, and `event_o` after the third. A captured narrow pulse in level mode lasts through edge five and has gone by edge six. The bench drives every stimulus on a falling edge, or inside the half cycle that follows one, and samples on a later falling edge after exactly that number of rising edges. For blanking and held-high lines, it samples on every falling edge of the window, so that a pulse appearing one cycle early or late is still caught.

// File: rtl/evr_pkg.sv
`timescale 1ns/1ps
package evr_pkg;
  localparam int unsigned EVR_SYNC_MIN = 2;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/evr_src_mux.sv
`timescale 1ns/1ps
module evr_src_mux #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic [N_SRC-1:0] src_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             inv_i,
  output logic             cond_o
);
  logic sel_bit;

  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel_i == SEL_W'(i)) sel_bit = src_i[i];
    end
    cond_o = sel_bit ^ inv_i;
  end
endmodule

// File: rtl/evr_capture.sv
`timescale 1ns/1ps
module evr_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  input  logic cap_en_i,
  input  logic seen_i,
  output logic cap_o
);
  logic flag_q;
  logic clr_q;
  logic clr;

  assign clr = ~rst_ni | clr_q;

  // set by the event itself, so pulses shorter than a clock period are held
  always_ff @(posedge cond_i or posedge clr) begin
    if (clr) flag_q <= 1'b0;
    else     flag_q <= 1'b1;
  end

  // held clear while capture is off; cleared once the sync copy is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= 1'b0;
    else         clr_q <= ~cap_en_i | seen_i;
  end

  assign cap_o = cap_en_i ? flag_q : cond_i;

  a_r5_flag_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> !flag_q);
endmodule

// File: rtl/evr_sync.sv
`timescale 1ns/1ps
module evr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/evr_shaper.sv
`timescale 1ns/1ps
module evr_shaper #(
  parameter int unsigned CFG_W     = 4,
  parameter int unsigned BLANK_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             lvl_i,
  input  logic             pulse_en_i,
  output logic             event_o
);
  localparam int unsigned CNT_W = evr_pkg::cnt_w(BLANK_CYC);

  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             prev_q;
  logic             event_q;
  logic             cfg_chg;
  logic             blank;
  logic             rise;

  assign cfg_chg = (cfg_i != cfg_q);
  assign blank   = (cnt_q != '0);
  assign rise    = lvl_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      cnt_q   <= '0;
      prev_q  <= 1'b0;
      event_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_i;
      prev_q <= lvl_i;
      if (cfg_chg)    cnt_q <= CNT_W'(BLANK_CYC);
      else if (blank) cnt_q <= cnt_q - CNT_W'(1);
      event_q <= pulse_en_i ? (rise & ~blank) : lvl_i;
    end
  end

  assign event_o = event_q;

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_en_i && event_q) |=> !(pulse_en_i && event_q));

  a_r7_blank_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_en_i && blank) |=> !event_q);
endmodule

// File: rtl/evr_route_cell.sv
`timescale 1ns/1ps
module evr_route_cell #(
  parameter int unsigned N_SRC       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [N_SRC-1:0]                     src_i,
  input  logic [(N_SRC > 1 ? $clog2(N_SRC) : 1)-1:0] sel_i,
  input  logic                                 inv_i,
  input  logic                                 cap_en_i,
  input  logic                                 pulse_en_i,
  output logic                                 event_o,
  output logic                                 sync_lvl_o
);
  localparam int unsigned SEL_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int unsigned STAGES    = (SYNC_STAGES < evr_pkg::EVR_SYNC_MIN) ?
                                      evr_pkg::EVR_SYNC_MIN : SYNC_STAGES;
  localparam int unsigned BLANK_CYC = STAGES;

  logic cond;
  logic cap;
  logic sync_lvl;

  evr_src_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux (
    .src_i (src_i),
    .sel_i (sel_i),
    .inv_i (inv_i),
    .cond_o(cond)
  );

  evr_capture u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cond_i  (cond),
    .cap_en_i(cap_en_i),
    .seen_i  (sync_lvl),
    .cap_o   (cap)
  );

  evr_sync #(.STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cap),
    .q_o   (sync_lvl)
  );

  evr_shaper #(.CFG_W(SEL_W + 1), .BLANK_CYC(BLANK_CYC)) u_shape (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     ({sel_i, inv_i}),
    .lvl_i     (sync_lvl),
    .pulse_en_i(pulse_en_i),
    .event_o   (event_o)
  );

  assign sync_lvl_o = sync_lvl;

  a_r9_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_en_i |=> (event_o == $past(sync_lvl)));

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r8_reset_idle: assert (!event_o && !sync_lvl_o);
    end
  end
endmodule

// File: tb/tb_evr_route_cell.sv
`timescale 1ns/1ps
module tb_evr_route_cell;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] src_i;
  logic [2:0] sel_i;
  logic       inv_i, cap_en_i, pulse_en_i;
  logic       event_o, sync_lvl_o;
  int         n_chk = 0;
  int         n_err = 0;

  always #2 clk_i = ~clk_i;

  evr_route_cell #(.N_SRC(8), .SYNC_STAGES(2)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .sel_i(sel_i), .inv_i(inv_i),
    .cap_en_i(cap_en_i), .pulse_en_i(pulse_en_i), .event_o(event_o), .sync_lvl_o(sync_lvl_o)
  );

  // {src[12:5], sel[4:2], inv[1], expected[0]}, level mode
  localparam logic [12:0] VEC [8] = '{
    {8'h00, 3'd0, 1'b0, 1'b0},
    {8'h01, 3'd0, 1'b0, 1'b1},
    {8'hFE, 3'd0, 1'b0, 1'b0},
    {8'hFE, 3'd0, 1'b1, 1'b1},
    {8'h04, 3'd2, 1'b0, 1'b1},
    {8'hFB, 3'd2, 1'b0, 1'b0},
    {8'h80, 3'd7, 1'b0, 1'b1},
    {8'h80, 3'd7, 1'b1, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // high pulse fully inside the half cycle after a falling edge
  task automatic narrow(input int b);
    #0.5 src_i[b] = 1'b1;
    #1   src_i[b] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; src_i = '0; sel_i = '0; inv_i = 1'b0;
    cap_en_i = 1'b0; pulse_en_i = 1'b0;
    tick(2);
    chk("R8 reset event", event_o, 1'b0);
    chk("R8 reset sync", sync_lvl_o, 1'b0);
    rst_ni = 1'b1;
    tick(3);

    // R1 R2 R9: level-mode vectors, sel changes not blanked
    for (int v = 0; v < 8; v++) begin
      src_i = VEC[v][12:5]; sel_i = VEC[v][4:2]; inv_i = VEC[v][1];
      tick(3);
      chk("R1/R2/R9 vec event", event_o, VEC[v][0]);
      chk("R1/R2 vec sync", sync_lvl_o, VEC[v][0]);
    end

    // R3 latency
    src_i = '0; sel_i = 3'd0; inv_i = 1'b0; tick(4);
    src_i[0] = 1'b1;
    tick(2);
    chk("R3 sync at edge 2", sync_lvl_o, 1'b1);
    chk("R3 event not yet", event_o, 1'b0);
    tick(1);
    chk("R3 event at edge 3", event_o, 1'b1);

    // R4 pulse mode
    src_i = '0; pulse_en_i = 1'b1; tick(4);
    src_i[0] = 1'b1;
    tick(2); chk("R4 no early pulse", event_o, 1'b0);
    tick(1); chk("R4 pulse", event_o, 1'b1);
    tick(1); chk("R4 one cycle", event_o, 1'b0);
    for (int i = 0; i < 4; i++) begin
      tick(1); chk("R4 held high", event_o, 1'b0);
    end
    src_i = '0; tick(4);
    src_i[0] = 1'b1; tick(3);
    chk("R4 second pulse", event_o, 1'b1);
    src_i = '0; tick(4);

    // R7 blanking after config changes
    inv_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick(1); chk("R7 invert change", event_o, 1'b0);
    end
    inv_i = 1'b0; tick(4);
    src_i = 8'h08; sel_i = 3'd3;
    for (int i = 0; i < 5; i++) begin
      tick(1); chk("R7 select change", event_o, 1'b0);
    end
    src_i = '0; sel_i = 3'd0; pulse_en_i = 1'b0; tick(4);

    // R6 narrow pulse missed without capture
    narrow(0);
    for (int i = 0; i < 4; i++) begin
      tick(1);
      chk("R6 event", event_o, 1'b0);
      chk("R6 sync", sync_lvl_o, 1'b0);
    end

    // R5 capture, level mode
    cap_en_i = 1'b1; tick(3);
    narrow(0);
    tick(3); chk("R5 captured level", event_o, 1'b1);
    tick(2); chk("R5 still high edge 5", event_o, 1'b1);
    tick(1); chk("R5 released edge 6", event_o, 1'b0);

    // R5 capture, pulse mode
    pulse_en_i = 1'b1; tick(4);
    narrow(0);
    tick(3); chk("R5 captured pulse", event_o, 1'b1);
    tick(1); chk("R5 pulse one cycle", event_o, 1'b0);
    pulse_en_i = 1'b0; tick(6);

    // R8 reset clears a pending capture
    narrow(0);
    #0.2 rst_ni = 1'b0;
    tick(2);
    chk("R8 reset event", event_o, 1'b0);
    chk("R8 reset sync", sync_lvl_o, 1'b0);
    rst_ni = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick(1); chk("R8 flag dropped", event_o, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule